// File: doc/BRIEF.md
# Delayed Gain Compensation Shifter

This block applies digital gain to a signed sample stream so that it cancels a step of analog attenuation ahead of the converter. A range control loop issues a 3-bit attenuation code. Each code step stands for 6 dB, so the codes cover 0 to 42 dB. The same code enters this block and passes through a programmable delay line. The delay matches the time the analog change needs to reach the digitized samples: attenuator settling, filter group delay and converter pipeline. The delayed code then sets a left barrel shift of one bit per step. The shift sits between the mixer path and the decimating filter, which keeps dynamic range through the mixer.

The delay line advances only on cycles that carry a valid sample. The delay is set as `delay_sel + 1` valid samples, from 1 to 256. A small controller has two states. ST_RUN is the normal state. In ST_RUN the controller compares `delay_sel` with the setting it holds. On a mismatch it takes the transition RUN→FLUSH. ST_FLUSH lasts one cycle. During that cycle the setting is loaded and every buffer entry is overwritten with the code at the `gain_code` input. Then the controller takes the transition FLUSH→RUN. The controller also leaves reset in ST_FLUSH, so the first setting and code are loaded at once.

Top module: `gain_align_shifter`

## Requirements
- R1: While reset is held and on the first cycle after it, out_valid, out_data and out_code are all 0.
- R2: A sample processed with applied code n (0..7) gives out_data equal to the sign-extended input times 2^n.
- R3: out_data is SAMPLE_W+7 bits wide. Full-scale positive and full-scale negative inputs shifted by 7 are exact, with no wrap.
- R4: With delay D = delay_sel+1, the code applied to the k-th valid sample is the gain_code presented with valid sample k−D. If fewer than D valid samples have passed since the last flush, the flush code is applied instead.
- R5: delay_sel = 0 (D = 1) applies a code to the next valid sample after the one it arrived with.
- R6: delay_sel = 255 (D = 256) applies a code to the 256th valid sample after its own.
- R7: Cycles with in_valid low do not advance the delay line, and their gain_code is discarded. On the cycle after them, out_valid is 0 and out_data holds its value.
- R8: out_valid follows in_valid one cycle later, and out_data/out_code belong to that sample.
- R9: A change of delay_sel causes RUN→FLUSH on the next edge. ST_FLUSH lasts one cycle and fills every entry with that cycle's gain_code, so no code from before the change is released afterwards.
- R10: out_code reports the code applied to the sample currently in out_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | SAMPLE_W (16) | Signed input sample |
| gain_code | input | CODE_W (3) | Attenuation code from the range loop, 6 dB per step |
| delay_sel | input | PTR_W (8) | Delay in valid samples minus one |
| out_valid | output | 1 | Output strobe |
| out_data | output | SAMPLE_W+7 (23) | Signed shifted sample |
| out_code | output | CODE_W (3) | Code applied to out_data |

## Verification
The bench builds the block with its default values: 16-bit samples, a 3-bit code and an 8-bit pointer. These values give a 256-entry buffer and a 23-bit output. With this build the bench can reach every shift from 0 to 7 and the full-scale extremes at shift 7. It can also reach both ends of the delay range, including the case where the read pointer wraps onto the entry about to be written at D = 256. Gapped streams and delay changes under a new fill code exercise the valid-only advance and the flush transition.

// File: rtl/gas_pkg.sv
package gas_pkg;
    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_FLUSH = 1'b1
    } gas_state_e;
endpackage

// File: rtl/gas_delay_line.sv
module gas_delay_line #(
    parameter int CODE_W = 3,
    parameter int PTR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic [CODE_W-1:0] fill_i,
    input  logic              adv_i,
    input  logic [CODE_W-1:0] wr_code_i,
    input  logic [PTR_W-1:0]  delay_m1_i,
    output logic [CODE_W-1:0] rd_code_o
);
    localparam int DEPTH = 1 << PTR_W;

    logic [CODE_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    // rd = wr - (delay_m1 + 1); at the full depth this is the slot about to be overwritten
    assign rd_ptr    = wr_ptr - delay_m1_i - PTR_W'(1);
    assign rd_code_o = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (flush_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= fill_i;
            end
        end else if (adv_i) begin
            mem[wr_ptr] <= wr_code_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (adv_i) begin
            wr_ptr <= wr_ptr + PTR_W'(1);
        end
    end

    // R9: after a flush every slot, hence the one read, holds the fill code
    assert_flush_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush_i) |-> rd_code_o == $past(fill_i));

    // R7: pointer frozen when no sample arrives
    assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(wr_ptr));
endmodule

// File: rtl/gas_shifter.sv
module gas_shifter #(
    parameter int IN_W   = 16,
    parameter int CODE_W = 3,
    parameter int OUT_W  = 23
) (
    input  logic signed [IN_W-1:0]  din,
    input  logic        [CODE_W-1:0] shift,
    output logic signed [OUT_W-1:0] dout
);
    logic signed [OUT_W-1:0] stage [CODE_W+1];

    assign stage[0] = OUT_W'(din);

    for (genvar g = 0; g < CODE_W; g++) begin : g_stage
        assign stage[g+1] = shift[g] ? (stage[g] <<< (1 << g)) : stage[g];
    end

    assign dout = stage[CODE_W];
endmodule

// File: rtl/gain_align_shifter.sv
module gain_align_shifter
    import gas_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int CODE_W   = 3,
    parameter int PTR_W    = 8,
    localparam int MAX_SHIFT = (1 << CODE_W) - 1,
    localparam int OUT_W     = SAMPLE_W + MAX_SHIFT
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_data,
    input  logic        [CODE_W-1:0]   gain_code,
    input  logic        [PTR_W-1:0]    delay_sel,
    output logic                       out_valid,
    output logic signed [OUT_W-1:0]    out_data,
    output logic        [CODE_W-1:0]   out_code
);
    gas_state_e        state_q, state_d;
    logic [PTR_W-1:0]  dly_q;
    logic              flush;
    logic [CODE_W-1:0] rd_code;
    logic [CODE_W-1:0] code_sel;
    logic signed [OUT_W-1:0] shifted;
    logic signed [OUT_W-1:0] in_ext;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FLUSH;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (delay_sel != dly_q) state_d = ST_FLUSH;
            ST_FLUSH: state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    // state-driven outputs
    always_comb begin
        flush    = 1'b0;
        code_sel = rd_code;
        unique case (state_q)
            ST_RUN:   ;
            ST_FLUSH: begin
                flush    = 1'b1;
                code_sel = gain_code;
            end
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     dly_q <= '0;
        else if (flush) dly_q <= delay_sel;
    end

    gas_delay_line #(.CODE_W(CODE_W), .PTR_W(PTR_W)) u_dly (
        .clk(clk), .rst_n(rst_n),
        .flush_i(flush), .fill_i(gain_code),
        .adv_i(in_valid), .wr_code_i(gain_code),
        .delay_m1_i(dly_q), .rd_code_o(rd_code)
    );

    gas_shifter #(.IN_W(SAMPLE_W), .CODE_W(CODE_W), .OUT_W(OUT_W)) u_shift (
        .din(in_data), .shift(code_sel), .dout(shifted)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_code  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= shifted;
                out_code <= code_sel;
            end
        end
    end

    assign in_ext = OUT_W'(in_data);

    // R3: shifting back recovers the input exactly
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid) && $past(rst_n) |-> (out_data >>> out_code) == $past(in_ext));

    // R8: one-cycle strobe latency
    assert_valid_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R7: idle cycle leaves data untouched
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(out_data));

    // R9: flush lasts exactly one cycle
    assert_flush_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_FLUSH |=> state_q == ST_RUN);

    // R9: mismatch in run leads to flush
    assert_mismatch_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_RUN && delay_sel != dly_q |=> state_q == ST_FLUSH);
endmodule

// File: tb/tb_gain_align_shifter.sv
module tb_gain_align_shifter;
    localparam int SAMPLE_W = 16;
    localparam int CODE_W   = 3;
    localparam int PTR_W    = 8;
    localparam int OUT_W    = SAMPLE_W + 7;

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid;
    logic signed [SAMPLE_W-1:0] in_data;
    logic [CODE_W-1:0] gain_code;
    logic [PTR_W-1:0]  delay_sel;
    logic out_valid;
    logic signed [OUT_W-1:0] out_data;
    logic [CODE_W-1:0] out_code;

    int total = 0;
    int bad   = 0;

    // pending expectation from the previous drive
    logic    pend;
    logic    pend_v;
    longint  exp_data;
    int      exp_code;
    string   code_tag;
    longint  last_data;

    int hist [0:1023];

    always #4 clk = ~clk;

    gain_align_shifter #(.SAMPLE_W(SAMPLE_W), .CODE_W(CODE_W), .PTR_W(PTR_W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .gain_code(gain_code), .delay_sel(delay_sel),
        .out_valid(out_valid), .out_data(out_data), .out_code(out_code)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_pending();
        if (pend) begin
            if (pend_v) begin
                check("R8 out_valid", longint'(out_valid), 1);
                check("R2 out_data", longint'(out_data), exp_data);
                check({code_tag, " R10 out_code"}, longint'(out_code), longint'(exp_code));
                last_data = longint'(out_data);
            end else begin
                check("R7 out_valid idle", longint'(out_valid), 0);
                check("R7 out_data hold", longint'(out_data), last_data);
            end
        end
        pend = 1'b0;
    endtask

    task automatic drive(input logic v, input logic signed [SAMPLE_W-1:0] d,
                         input int c, input int applied);
        @(negedge clk);
        check_pending();
        in_valid  = v;
        in_data   = d;
        gain_code = CODE_W'(c);
        pend      = 1'b1;
        pend_v    = v;
        exp_code  = applied;
        exp_data  = longint'(d) * (64'sd1 <<< applied);
    endtask

    task automatic finish_stream();
        @(negedge clk);
        check_pending();
        in_valid = 1'b0;
    endtask

    // flush twice so the requested setting always differs from the held one
    task automatic set_delay(input int dm1, input int fill);
        @(negedge clk);
        in_valid  = 1'b0;
        gain_code = CODE_W'(fill);
        delay_sel = ~PTR_W'(dm1);
        repeat (3) @(negedge clk);
        delay_sel = PTR_W'(dm1);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_seq(input int dm1, input int fill, input int n,
                           input bit gaps, input int seed, input string tag);
        int d;
        d = dm1 + 1;
        set_delay(dm1, fill);
        for (int k = 0; k < n; k++) begin
            int c;
            int ap;
            logic signed [SAMPLE_W-1:0] x;
            c = (k * 5 + seed) % 8;
            x = SAMPLE_W'(k * 7919 + seed * 31);
            if (k % 11 == 3) x = -16'sd32768;
            hist[k] = c;
            ap = (k < d) ? fill : hist[k - d];
            if (gaps && (k % 3 == 1)) drive(1'b0, x ^ 16'h5a5a, (c + 3) % 8, 0);
            code_tag = tag;
            drive(1'b1, x, c, ap);
        end
        finish_stream();
    endtask

    task automatic t_reset();
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0; gain_code = '0; delay_sel = '0;
        pend = 1'b0; last_data = 0;
        repeat (4) @(negedge clk);
        check("R1 out_valid in reset", longint'(out_valid), 0);
        check("R1 out_data in reset", longint'(out_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", longint'(out_valid), 0);
        check("R1 out_code after reset", longint'(out_code), 0);
        check("R1 out_data after reset", longint'(out_data), 0);
    endtask

    task automatic t_extremes();
        set_delay(0, 7);
        code_tag = "R3";
        drive(1'b1, 16'sh7fff, 7, 7);
        drive(1'b1, -16'sd32768, 7, 7);
        drive(1'b1, -16'sd1, 0, 7);
        drive(1'b1, 16'sd1, 0, 0);
        finish_stream();
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        run_seq(0, 0, 24, 1'b0, 1, "R5");     // shift sweep, D=1
        t_extremes();
        run_seq(4, 2, 40, 1'b1, 3, "R4");     // mid delay with idle gaps (R7)
        run_seq(9, 6, 30, 1'b0, 5, "R9");     // flush code seen for first 10
        run_seq(255, 5, 300, 1'b0, 2, "R6");  // full depth
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule